// File: doc/BRIEF.md
# Triangle-Sweep Timer Counter

This block is a 16-bit timer counter that sweeps a count value back and forth between zero and a programmable limit, producing a triangle sequence. On the way up it turns around at the limit with an overflow pulse. On the way down it turns around at zero with an underflow pulse. A compare register raises a match pulse whenever the count lands on its value. A two-bit mode field chooses which sweep direction may raise that pulse. With the mode field at zero the block is a plain wrapping up or down counter.

Software drives the block through a small write/read register port. It can set the count value and the starting direction first and then enable the counter. Enabling keeps both values, so the sweep can start at any point and in either direction. While a center mode is active, the direction bit belongs to the hardware and can only be read. Each event pulse is also captured in a sticky status bit, and software clears that bit by writing 1 to it.

Top module: `tri_timer`

## Requirements
- R1: In a center mode (mode field non-zero), with limit L > 0 and the counter counting up, the count rises by one per cycle. The step from L-1 to L turns the direction to down (direction bit 1) and raises a one-cycle overflow pulse. The overflow and underflow pulses are never high together.
- R2: In a center mode, counting down, the count falls by one per cycle. The step from 1 to 0 turns the direction to up (direction bit 0) and raises a one-cycle underflow pulse. A full sweep therefore lasts 2L cycles.
- R3: Register map: address 0 is control, address 1 is the limit, address 2 is the count, address 3 is the compare value and address 4 is status. Control bit 0 is enable, bit 1 is direction (0 up, 1 down) and bits 3:2 are the mode field. A read of address 0 returns the current hardware direction. Status bit 0 is overflow, bit 1 is underflow and bit 2 is compare. A read of any other address returns 0.
- R4: A control write changes the direction bit only if the stored mode field is 00 before the write. In any other mode the written direction is ignored.
- R5: While enable is 1 and the stored mode is 00, a control write with a non-zero mode field leaves the mode at 00. The other bits of that write still take effect.
- R6: Setting enable, or selecting a center mode, does not change the count or the direction. Counting starts from the preloaded count in the preloaded direction.
- R7: While enable is 1 the counter makes exactly one step per clock. While enable is 0 the count holds. A write to the count register takes priority: in that cycle no step happens and no event is raised.
- R8: A compare pulse is raised when a step lands the count on the compare value. The direction of the step decides whether it counts: mode 01 accepts only down steps, mode 10 only up steps, and modes 11 and 00 accept every step.
- R9: In a center mode, counting up with a count at or above L, the next step goes to L-1 and turns the direction to down, with an overflow pulse. In a center mode, counting down with a count of 0, the next step goes to 1 and turns the direction to up, with an underflow pulse.
- R10: Status bits are sticky. Each one is set by its pulse and cleared by writing 1 to it at address 4. A pulse in the same cycle as the clear wins.
- R11: With a limit of 0 and enable at 1, the count is held at 0 and no overflow, underflow or compare pulse is raised.
- R12: In mode 00, counting up steps from the limit to 0 with an overflow pulse. Counting down steps from 0 to the limit with an underflow pulse. In this mode the direction bit can be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` (combinational) |
| count_o | output | 16 | Current count |
| dir_o | output | 1 | Current direction, 1 means down |
| ovf_evt | output | 1 | One-cycle overflow pulse |
| unf_evt | output | 1 | One-cycle underflow pulse |
| cmp_evt | output | 1 | One-cycle compare-match pulse |

## Verification
The sweep is run from the default zero start and also from mid-range preloads in both directions, including the example of limit 20 with a count of 10 going down. The mid-range preloads show that enabling keeps the preloaded state, which a start from zero cannot reveal. Each of the four mode values is run with the same compare value. The compare pulse then appears on down steps only, on up steps only, or on both, and this separates the direction qualifiers. Preloads above the limit, a limit of 0, a rejected mode change while running, and ignored direction writes check the turn-around and locking rules that a normal sweep never reaches.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    typedef enum logic [1:0] {
        M_EDGE    = 2'b00,
        M_CTR_DN  = 2'b01,
        M_CTR_UP  = 2'b10,
        M_CTR_ALL = 2'b11
    } sweep_mode_e;
endpackage

// File: rtl/tt_step.sv
module tt_step #(
    parameter int CW = 16
) (
    input  logic          center,
    input  logic          dir,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] nxt_cnt,
    output logic          nxt_dir,
    output logic          ovf,
    output logic          unf
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        nxt_cnt = cnt;
        nxt_dir = dir;
        ovf     = 1'b0;
        unf     = 1'b0;
        if (limit == '0) begin
            nxt_cnt = '0;
        end else if (center) begin
            if (!dir) begin
                if (cnt >= limit) begin
                    nxt_cnt = limit - ONE;
                    nxt_dir = 1'b1;
                    ovf     = 1'b1;
                end else if (cnt == limit - ONE) begin
                    nxt_cnt = limit;
                    nxt_dir = 1'b1;
                    ovf     = 1'b1;
                end else begin
                    nxt_cnt = cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    nxt_cnt = ONE;
                    nxt_dir = 1'b0;
                    unf     = 1'b1;
                end else if (cnt == ONE) begin
                    nxt_cnt = '0;
                    nxt_dir = 1'b0;
                    unf     = 1'b1;
                end else begin
                    nxt_cnt = cnt - ONE;
                end
            end
        end else begin
            if (!dir) begin
                if (cnt >= limit) begin
                    nxt_cnt = '0;
                    ovf     = 1'b1;
                end else begin
                    nxt_cnt = cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    nxt_cnt = limit;
                    unf     = 1'b1;
                end else begin
                    nxt_cnt = cnt - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/tt_cmp.sv
module tt_cmp #(
    parameter int CW = 16
) (
    input  logic          step_valid,
    input  logic [1:0]    mode,
    input  logic          step_dir,
    input  logic [CW-1:0] landed,
    input  logic [CW-1:0] cmp_val,
    output logic          hit
);
    import tt_pkg::*;

    logic dir_ok;

    always_comb begin
        case (sweep_mode_e'(mode))
            M_CTR_DN: dir_ok = step_dir;
            M_CTR_UP: dir_ok = !step_dir;
            default:  dir_ok = 1'b1;
        endcase
        hit = step_valid && dir_ok && (landed == cmp_val);
    end
endmodule

// File: rtl/tri_timer.sv
module tri_timer #(
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             addr,
    input  logic [CW-1:0]          wdata,
    output logic [CW-1:0]          rdata,
    output logic [CW-1:0]          count_o,
    output logic                   dir_o,
    output logic                   ovf_evt,
    output logic                   unf_evt,
    output logic                   cmp_evt
);
    import tt_pkg::*;

    localparam int STW = 3;

    typedef struct packed {
        logic           en;
        logic           dir;
        logic [1:0]     mode;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  limit;
        logic [CW-1:0]  cmpv;
        logic [STW-1:0] stat;
        logic           ovf_p;
        logic           unf_p;
        logic           cmp_p;
    } tt_state_t;

    tt_state_t s_d, s_q;

    logic [CW-1:0] step_cnt;
    logic          step_dir;
    logic          step_ovf;
    logic          step_unf;
    logic          step_hit;
    logic          cnt_wr;
    logic          stepping;

    assign cnt_wr   = wr_en && (addr == A_COUNT);
    assign stepping = s_q.en && !cnt_wr;

    tt_step #(.CW(CW)) u_step (
        .center  (s_q.mode != M_EDGE),
        .dir     (s_q.dir),
        .cnt     (s_q.cnt),
        .limit   (s_q.limit),
        .nxt_cnt (step_cnt),
        .nxt_dir (step_dir),
        .ovf     (step_ovf),
        .unf     (step_unf)
    );

    tt_cmp #(.CW(CW)) u_cmp (
        .step_valid (stepping && (s_q.limit != '0)),
        .mode       (s_q.mode),
        .step_dir   (s_q.dir),
        .landed     (step_cnt),
        .cmp_val    (s_q.cmpv),
        .hit        (step_hit)
    );

    always_comb begin
        logic [STW-1:0] clr;
        s_d       = s_q;
        s_d.ovf_p = 1'b0;
        s_d.unf_p = 1'b0;
        s_d.cmp_p = 1'b0;
        clr       = '0;

        if (stepping) begin
            s_d.cnt   = step_cnt;
            s_d.dir   = step_dir;
            s_d.ovf_p = step_ovf;
            s_d.unf_p = step_unf;
            s_d.cmp_p = step_hit;
        end

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    s_d.en = wdata[0];
                    if (s_q.mode == M_EDGE)
                        s_d.dir = wdata[1];
                    if (!(s_q.en && (s_q.mode == M_EDGE) && (wdata[3:2] != 2'b00)))
                        s_d.mode = wdata[3:2];
                end
                A_LIMIT:  s_d.limit = wdata;
                A_COUNT:  s_d.cnt   = wdata;
                A_CMP:    s_d.cmpv  = wdata;
                A_STATUS: clr       = wdata[STW-1:0];
                default: ;
            endcase
        end

        s_d.stat = (s_q.stat & ~clr) | {s_d.cmp_p, s_d.unf_p, s_d.ovf_p};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:   rdata = {{(CW-4){1'b0}}, s_q.mode, s_q.dir, s_q.en};
            A_LIMIT:  rdata = s_q.limit;
            A_COUNT:  rdata = s_q.cnt;
            A_CMP:    rdata = s_q.cmpv;
            A_STATUS: rdata = {{(CW-STW){1'b0}}, s_q.stat};
            default:  rdata = '0;
        endcase
    end

    assign count_o = s_q.cnt;
    assign dir_o   = s_q.dir;
    assign ovf_evt = s_q.ovf_p;
    assign unf_evt = s_q.unf_p;
    assign cmp_evt = s_q.cmp_p;

    logic          en_s;
    logic [1:0]    mode_s;
    logic [CW-1:0] limit_s;
    assign en_s    = s_q.en;
    assign mode_s  = s_q.mode;
    assign limit_s = s_q.limit;
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic          en_s,
    input logic [1:0]    mode_s,
    input logic [CW-1:0] limit_s,
    input logic [CW-1:0] count_o,
    input logic          dir_o,
    input logic          ovf_evt,
    input logic          unf_evt
);
    assert_evt_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_evt && unf_evt));

    assert_ovf_turns_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && mode_s != 2'b00) |-> dir_o);

    assert_unf_turns_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_evt && mode_s != 2'b00) |-> !dir_o);

    assert_dir_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && mode_s != 2'b00 && !en_s) |=> (dir_o == $past(dir_o)));

    assert_mode_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && en_s && mode_s == 2'b00) |=> (mode_s == 2'b00));

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !(wr_en && addr == 3'd2)) |=> $stable(count_o));

    assert_zero_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && limit_s == '0 && !(wr_en && addr == 3'd2))
        |=> (count_o == '0 && !ovf_evt && !unf_evt));
endmodule

bind tri_timer tt_timer_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .en_s    (en_s),
    .mode_s  (mode_s),
    .limit_s (limit_s),
    .count_o (count_o),
    .dir_o   (dir_o),
    .ovf_evt (ovf_evt),
    .unf_evt (unf_evt)
);

// File: tb/sim_tri_timer.sv
module sim_tri_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, count_o;
    logic        dir_o, ovf_evt, unf_evt, cmp_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R3";

    int m_en, m_dir, m_mode, m_cnt, m_lim, m_cmp, m_st, m_ov, m_un, m_ch;

    always #5 clk = ~clk;

    tri_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .count_o(count_o), .dir_o(dir_o),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .cmp_evt(cmp_evt)
    );

    function automatic int mread(input int a);
        case (a)
            0: return m_mode * 4 + m_dir * 2 + m_en;
            1: return m_lim;
            2: return m_cnt;
            3: return m_cmp;
            4: return m_st;
            default: return 0;
        endcase
    endfunction

    task automatic tick();
        int nc = m_cnt, nd = m_dir, ov = 0, un = 0, ch = 0;
        int ne = m_en, nm = m_mode, nl = m_lim, ncm = m_cmp, clr = 0;
        bit cw = wr_en && addr == 3'd2;
        if (m_en != 0 && !cw) begin
            if (m_lim == 0) nc = 0;
            else begin
                if (m_mode != 0) begin
                    if (m_dir == 0) begin
                        if (m_cnt >= m_lim)          begin nc = m_lim - 1; nd = 1; ov = 1; end
                        else if (m_cnt + 1 == m_lim) begin nc = m_lim; nd = 1; ov = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0)      begin nc = 1; nd = 0; un = 1; end
                        else if (m_cnt == 1) begin nc = 0; nd = 0; un = 1; end
                        else nc = m_cnt - 1;
                    end
                end else begin
                    if (m_dir == 0) begin
                        if (m_cnt >= m_lim) begin nc = 0; ov = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin nc = m_lim; un = 1; end
                        else nc = m_cnt - 1;
                    end
                end
                ch = (nc == m_cmp) && (m_mode == 0 || m_mode == 3 ||
                      (m_mode == 1 && m_dir == 1) || (m_mode == 2 && m_dir == 0));
            end
        end
        if (wr_en) begin
            case (addr)
                3'd0: begin
                    ne = wdata[0];
                    if (m_mode == 0) nd = wdata[1];
                    if (!(m_en != 0 && m_mode == 0 && wdata[3:2] != 0)) nm = wdata[3:2];
                end
                3'd1: nl = wdata;
                3'd2: nc = wdata;
                3'd3: ncm = wdata;
                3'd4: clr = wdata[2:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_st = (m_st & ~clr) | (ch * 4 + un * 2 + ov);
        m_cnt = nc; m_dir = nd; m_ov = ov; m_un = un; m_ch = ch;
        m_en = ne; m_mode = nm; m_lim = nl; m_cmp = ncm;
        wr_en = 1'b0;
        checks++;
        if (count_o != m_cnt || dir_o != m_dir || ovf_evt != m_ov ||
            unf_evt != m_un || cmp_evt != m_ch) begin
            errors++;
            $display("FAIL %s cycle: actual cnt=%0d dir=%0d ov=%0d un=%0d cmp=%0d expected cnt=%0d dir=%0d ov=%0d un=%0d cmp=%0d",
                     tag, count_o, dir_o, ovf_evt, unf_evt, cmp_evt,
                     m_cnt, m_dir, m_ov, m_un, m_ch);
        end
    endtask

    task automatic wr(input int a, input int d);
        addr = a[2:0]; wdata = d[15:0]; wr_en = 1'b1;
        tick();
    endtask

    task automatic rd(input int a, input string t);
        addr = a[2:0]; wr_en = 1'b0;
        #1;
        checks++;
        if (rdata != mread(a)) begin
            errors++;
            $display("FAIL %s read addr %0d: actual %0d expected %0d", t, a, rdata, mread(a));
        end
        tick();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        m_en = 0; m_dir = 0; m_mode = 0; m_cnt = 0; m_lim = 0; m_cmp = 0;
        m_st = 0; m_ov = 0; m_un = 0; m_ch = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        tag = "R3";
        for (int a = 0; a < 6; a++) rd(a, "R3");

        tag = "R1";
        wr(1, 4); wr(3, 2);
        wr(0, 13);                     // enable, mode 11
        run(20);
        tag = "R10";
        rd(4, "R10");
        wr(4, 7); rd(4, "R10");

        tag = "R4";
        wr(0, 12);                     // stop, keep mode 11
        wr(2, 2);
        wr(0, 14);                     // direction write must be ignored
        rd(0, "R4");
        tag = "R8";
        wr(0, 5); run(12);             // mode 01
        wr(0, 9); run(12);             // mode 10
        tag = "R2";
        run(10);

        tag = "R6";
        wr(0, 0);                      // back to edge, stopped
        wr(1, 20); wr(2, 10);
        wr(0, 15);                     // down, mode 11, enable together
        rd(0, "R6");
        run(30);

        tag = "R12";
        wr(0, 0); wr(1, 5); wr(2, 3);
        wr(0, 1); run(10);             // edge up
        tag = "R5";
        wr(0, 13); rd(0, "R5");        // mode change refused while running
        tag = "R12";
        wr(0, 3); run(10);             // edge down

        tag = "R9";
        wr(0, 0); wr(2, 9);
        wr(0, 12); wr(0, 13); run(8);
        wr(0, 12); wr(2, 0);
        wr(0, 0); wr(0, 2); wr(0, 14); wr(0, 15); run(6);

        tag = "R7";
        wr(2, 3); run(3);
        wr(0, 12); run(4); rd(2, "R7");

        tag = "R11";
        wr(1, 0); wr(0, 13); run(6);
        rd(2, "R11");

        tag = "R10";
        wr(1, 3); wr(4, 7); run(7);
        rd(4, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog: actual no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule